// File: doc/BRIEF.md
# Frame-End Bandwidth Reclamation Gate

This block sits next to the frame timer of a full-speed USB host. When the scheduler wants to start one more reclamation transaction late in a frame, the gate decides whether enough bit-times remain. It compares the time left against the cost of a packet of the programmed size plus fixed protocol overhead. If the gate allows the transaction, it then watches the bytes that move on the bus. A transaction that was allowed inside the frame-end critical window and carries more bytes than the programmed size is reported as babble, and the offending endpoint is asked to stall.

A size-select input chooses a small (32-byte) or large (64-byte) packet budget. A request refused for lack of time locks out further requests until the next frame begins.

Top module: `fs_reclaim_gate`

## Requirements
- R1: The size-select input `maxp_sel` picks the budget: 0 means 32 bytes and 1 means 64 bytes. The time needed is budget×8 + 64 bit-times, which is 320 for the small budget and 576 for the large one.
- R2: A `req` pulse produces a one-cycle `permit` in the next cycle only if `time_left` is at least the time needed, no transaction is active and the gate is not locked.
- R3: A permitted transaction is critical if `time_left` was below 576 when it was permitted. In such a transaction, the byte strobe that takes the count above the budget raises `babble` in the next cycle.
- R4: `stall_req` pulses in exactly the same cycle as `babble`.
- R5: A request refused because time is short locks the gate. While locked, later requests are refused, even with ample time. A `frame_start` pulse clears the lock.
- R6: `babble` is a single-cycle pulse and fires at most once per transaction.
- R7: A transaction permitted outside the critical window never raises `babble`, whatever its length.
- R8: The byte count restarts from zero at each permitted start.
- R9: After reset, `permit`, `babble` and `stall_req` are low, no transaction is active and the gate is unlocked.
- R10: A request made while a transaction is active is ignored: it gives no `permit` and does not lock the gate.
- R11: The budget is captured when the transaction is permitted, so a change of `maxp_sel` during the transaction has no effect on babble detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Pulse at the start of each frame; clears the lock |
| time_left | input | TIME_W | Remaining bit-times in the current frame |
| maxp_sel | input | 1 | Budget select: 0 for 32 bytes, 1 for 64 bytes |
| req | input | 1 | Request to start a reclamation transaction |
| byte_stb | input | 1 | One pulse per byte seen on the bus |
| xfer_end | input | 1 | End of the running transaction |
| permit | output | 1 | Start granted (pulse) |
| babble | output | 1 | Babble error (pulse) |
| stall_req | output | 1 | Stall request for the endpoint (pulse) |

## Verification
The bench sweeps `time_left` across the exact thresholds of 320 and 576 for both budgets. A comparison off by one would permit or refuse at the boundary value. In the critical window it sends exactly 32 and then 33 bytes. A design that counts before it clears, or that compares with the wrong sign, would flag babble one byte early or one byte late. It also covers the following:
- A refused request followed by a well-timed one in the same frame, which a design without the lock would wrongly grant.
- A request made during an active transfer.
- A budget change in the middle of a transfer, which a design that decodes the budget live would turn into a missed babble.

// File: rtl/fs_reclaim_gate.sv
module fs_reclaim_gate #(
  parameter int TIME_W      = 14,
  parameter int BYTE_W      = 8,
  parameter int SMALL_BYTES = 32,
  parameter int LARGE_BYTES = 64,
  parameter int OVERHEAD    = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic [TIME_W-1:0] time_left,
  input  logic              maxp_sel,
  input  logic              req,
  input  logic              byte_stb,
  input  logic              xfer_end,
  output logic              permit,
  output logic              babble,
  output logic              stall_req
);
  localparam int NEED_S = SMALL_BYTES * 8 + OVERHEAD;
  localparam int NEED_L = LARGE_BYTES * 8 + OVERHEAD;
  localparam logic [BYTE_W-1:0] CNT_MAX = {BYTE_W{1'b1}};

  logic              active, crit, flagged, locked;
  logic [BYTE_W-1:0] cnt, budget_q;

  wire [TIME_W-1:0] need      = maxp_sel ? TIME_W'(NEED_L) : TIME_W'(NEED_S);
  wire              enough    = time_left >= need;
  wire              in_window = time_left < TIME_W'(NEED_L);
  wire              lock_eff  = locked & ~frame_start;
  wire              grant     = req & ~active & ~lock_eff & enough;
  wire              deny_time = req & ~active & ~enough;
  wire [BYTE_W-1:0] cnt_nxt   = (cnt == CNT_MAX) ? cnt : cnt + 1'b1;
  wire              over      = active & byte_stb & crit & ~flagged & (cnt_nxt > budget_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      permit    <= 1'b0;
      babble    <= 1'b0;
      stall_req <= 1'b0;
      active    <= 1'b0;
      crit      <= 1'b0;
      flagged   <= 1'b0;
      locked    <= 1'b0;
      cnt       <= '0;
      budget_q  <= '0;
    end else begin
      permit    <= grant;
      babble    <= over;
      stall_req <= over;
      if (frame_start) locked <= 1'b0;
      if (deny_time)   locked <= 1'b1;
      if (grant) begin
        active   <= 1'b1;
        crit     <= in_window;
        cnt      <= '0;
        flagged  <= 1'b0;
        budget_q <= maxp_sel ? BYTE_W'(LARGE_BYTES) : BYTE_W'(SMALL_BYTES);
      end else begin
        if (xfer_end)          active  <= 1'b0;
        if (active & byte_stb) cnt     <= cnt_nxt;
        if (over)              flagged <= 1'b1;
      end
    end
  end

  assert_permit_time_R2: assert property (@(posedge clk) disable iff (!rst_n)
    permit |-> ($past(time_left) >= ($past(maxp_sel) ? TIME_W'(NEED_L) : TIME_W'(NEED_S))));
  assert_babble_crit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    babble |-> $past(crit && byte_stb && active));
  assert_stall_with_babble_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stall_req == babble);
  assert_lock_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    permit |-> $past(!locked || frame_start));
  assert_babble_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    babble |=> !babble);
  assert_no_window_no_babble_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !crit) |=> !babble);
endmodule

// File: tb/tb_fs_reclaim_gate.sv
module tb_fs_reclaim_gate;
  localparam int CLK_PERIOD = 10;
  localparam int N = 10;
  localparam int T_TIME [N] = '{1000, 320, 319, 576, 575, 400, 400, 0, 12000, 577};
  localparam bit T_MAXP [N] = '{0,    0,   0,   1,   1,   1,   0,   0, 1,     1};
  localparam bit T_EXP  [N] = '{1,    1,   0,   1,   0,   0,   1,   0, 1,     1};

  logic clk = 0, rst_n = 0, frame_start = 0, maxp_sel = 0, req = 0, byte_stb = 0, xfer_end = 0;
  logic [13:0] time_left = '0;
  logic permit, babble, stall_req;
  int tests = 0, fails = 0;
  bit done = 0;

  fs_reclaim_gate dut (.clk, .rst_n, .frame_start, .time_left, .maxp_sel, .req,
                       .byte_stb, .xfer_end, .permit, .babble, .stall_req);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string r, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic new_frame();
    frame_start = 1; @(negedge clk); frame_start = 0;
  endtask

  task automatic do_req(input int t, input bit m);
    time_left = 14'(t); maxp_sel = m; req = 1; @(negedge clk); req = 0;
  endtask

  task automatic end_xfer();
    xfer_end = 1; @(negedge clk); xfer_end = 0;
  endtask

  task automatic send_bytes(input int n, output int babs, output int stalls);
    babs = 0; stalls = 0;
    for (int i = 0; i < n; i++) begin
      byte_stb = 1; @(negedge clk); byte_stb = 0;
      babs += babble; stalls += stall_req;
    end
  endtask

  initial begin
    int b, s;
    repeat (3) @(negedge clk);
    chk("R9 permit after reset", permit, 0);
    chk("R9 babble after reset", babble, 0);
    chk("R9 stall after reset", stall_req, 0);
    rst_n = 1; @(negedge clk);

    for (int k = 0; k < N; k++) begin
      new_frame();
      do_req(T_TIME[k], T_MAXP[k]);
      chk($sformatf("R1/R2 vector %0d", k), permit, T_EXP[k]);
      @(negedge clk);
      chk("R2 permit is a pulse", permit, 0);
      if (T_EXP[k]) end_xfer();
    end

    new_frame(); do_req(400, 0);
    chk("R3 grant in window", permit, 1);
    send_bytes(32, b, s);
    chk("R3 no babble at budget", b, 0);
    send_bytes(1, b, s);
    chk("R3 babble on byte 33", b, 1);
    chk("R4 stall with babble", s, 1);
    @(negedge clk);
    chk("R6 babble single cycle", babble, 0);
    send_bytes(5, b, s);
    chk("R6 babble once per transfer", b, 0);
    do_req(1000, 0);
    chk("R10 req while active ignored", permit, 0);
    end_xfer();
    do_req(1000, 0);
    chk("R10 no lock from active req", permit, 1);
    end_xfer();

    do_req(400, 0);
    chk("R8 regrant", permit, 1);
    send_bytes(32, b, s);
    chk("R8 count cleared at start", b, 0);
    end_xfer();

    new_frame(); do_req(1000, 0);
    send_bytes(80, b, s);
    chk("R7 no babble outside window", b, 0);
    chk("R7 no stall outside window", s, 0);
    end_xfer();

    new_frame(); do_req(400, 0);
    maxp_sel = 1;
    send_bytes(33, b, s);
    chk("R11 budget latched at grant", b, 1);
    end_xfer();

    new_frame(); do_req(300, 0);
    chk("R5 short time denied", permit, 0);
    do_req(1000, 1);
    chk("R5 locked until frame start", permit, 0);
    new_frame(); do_req(1000, 1);
    chk("R5 frame start clears lock", permit, 1);
    end_xfer();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule